// File: doc/BRIEF.md
# Shared MixColumns / Inverse MixColumns Unit

This block applies the column-mixing step of the AES round to a 128-bit state. It works in either direction: forward mixing for encryption, or inverse mixing for decryption. A single mode input picks the direction. Every state byte goes through its own product generator. The generator builds all the Galois-field multiples that either matrix needs, using a short chain of doubling stages. Each result byte is then the XOR of four products, one taken from each byte of its column.

The unit sits in a round pipeline between the row-shift and key-addition stages. The caller presents a state together with a valid strobe. The transformed state appears one clock later on a registered output, together with its own valid flag. The number of columns handled in parallel is a parameter. The default handles all four columns of a 128-bit state; the other legal setting handles a single 32-bit column.

Top module: `mix_col_unit`

## Requirements
- R1: While reset is asserted, and on the first edge after it, `out_valid` is 0 and `out_state` is all zeros.
- R2: With `mode_i` = 0, each column (b0,b1,b2,b3) is multiplied by the circulant matrix whose top row is 02 03 01 01. Byte b0 is the most significant byte of its column, and column 0 occupies bits [127:96].
- R3: With `mode_i` = 1, each column is multiplied by the circulant matrix whose top row is 0E 0B 0D 09, using the same byte and column order as R2.
- R4: Doubling in GF(2^8) shifts left by one bit and XORs in 0x1B when bit 7 was set. Bytes with bit 7 high therefore reduce correctly in every product.
- R5: A result appears exactly one clock after its input. `out_valid` equals the `in_valid` of the previous cycle.
- R6: When `in_valid` is 0, `out_state` keeps its value, whatever `in_state` and `mode_i` do.
- R7: Each column's output depends only on that column's input bytes.
- R8: Passing the forward result through inverse mode returns the original state, and the reverse also holds.
- R9: `mode_i` may change on every valid cycle. Each result uses the mode that was sampled with its own input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = forward mixing, 1 = inverse mixing |
| in_valid | input | 1 | Input state is valid this cycle |
| in_state | input | 32*COLS | State to transform, column 0 in the top bits |
| out_valid | output | 1 | Registered result is valid |
| out_state | output | 32*COLS | Registered transformed state |

## Verification
Forward and inverse mixing can occupy back-to-back cycles, because the mode travels with each input rather than being held as a setting. The bench provokes this by presenting a forward input and then an inverse input on consecutive edges. It judges each registered result against a bench-side matrix model evaluated in the mode of that result's own input. A second overlap lies in the hold path. In an idle cycle the direction and data inputs can still change, and the bench confirms that the registered state stays put while they do.

// File: rtl/mcu_pkg.sv
package mcu_pkg;

   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned COL_BYTES = 4;
   localparam int unsigned COL_W     = BYTE_W * COL_BYTES;

   typedef logic [BYTE_W-1:0] gf_byte_t;

   // every multiple either matrix needs, for one source byte
   typedef struct packed {
      gf_byte_t x1;
      gf_byte_t x2;
      gf_byte_t x3;
      gf_byte_t x9;
      gf_byte_t xb;
      gf_byte_t xd;
      gf_byte_t xe;
   } gf_prod_t;

   typedef enum logic {
      MC_FWD = 1'b0,
      MC_INV = 1'b1
   } mc_mode_e;

   // one doubling stage: shift, then conditional reduction
   function automatic gf_byte_t gf_dbl(input gf_byte_t a, input gf_byte_t poly);
      return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? poly : '0);
   endfunction

endpackage

// File: rtl/gf_prod_gen.sv
module gf_prod_gen
   import mcu_pkg::*;
#(
   parameter logic [7:0]  RED_POLY   = 8'h1B,
   parameter int unsigned DBL_STAGES = 3
) (
   input  gf_byte_t a,
   output gf_prod_t prod
);

   generate
      if (DBL_STAGES != 3) begin : g_bad_stages
         $error("gf_prod_gen: DBL_STAGES must be 3 to reach the x8 term");
      end
      if (RED_POLY[0] != 1'b1) begin : g_bad_poly
         $error("gf_prod_gen: reduction constant must be odd");
      end
   endgenerate

   gf_byte_t p2, p4, p8;

   // cascade of three doublings: x2 -> x4 -> x8
   assign p2 = gf_dbl(a,  RED_POLY);
   assign p4 = gf_dbl(p2, RED_POLY);
   assign p8 = gf_dbl(p4, RED_POLY);

   always_comb begin
      prod.x1 = a;
      prod.x2 = p2;
      prod.x3 = p2 ^ a;
      prod.x9 = p8 ^ a;
      prod.xb = p8 ^ p2 ^ a;
      prod.xd = p8 ^ p4 ^ a;
      prod.xe = p8 ^ p4 ^ p2;
   end

endmodule

// File: rtl/mc_column.sv
module mc_column
   import mcu_pkg::*;
#(
   parameter logic [7:0] RED_POLY = 8'h1B
) (
   input  logic             inv,
   input  logic [COL_W-1:0] col_in,
   output logic [COL_W-1:0] col_out
);

   gf_prod_t prod [COL_BYTES];
   gf_byte_t term [COL_BYTES][COL_BYTES];

   // coefficient for row offset k = (src - dst) mod 4
   function automatic gf_byte_t pick(input gf_prod_t p, input logic sel_inv,
                                     input logic [1:0] k);
      gf_byte_t r;
      if (!sel_inv) begin
         case (k)
            2'd0:    r = p.x2;
            2'd1:    r = p.x3;
            default: r = p.x1;
         endcase
      end else begin
         case (k)
            2'd0:    r = p.xe;
            2'd1:    r = p.xb;
            2'd2:    r = p.xd;
            default: r = p.x9;
         endcase
      end
      return r;
   endfunction

   generate
      for (genvar j = 0; j < COL_BYTES; j++) begin : g_src
         gf_prod_gen #(.RED_POLY(RED_POLY), .DBL_STAGES(3)) u_prod (
            .a    (col_in[COL_W-1-BYTE_W*j -: BYTE_W]),
            .prod (prod[j])
         );
      end
      for (genvar i = 0; i < COL_BYTES; i++) begin : g_dst
         for (genvar j = 0; j < COL_BYTES; j++) begin : g_term
            localparam logic [1:0] OFS = 2'((j - i + COL_BYTES) % COL_BYTES);
            assign term[i][j] = pick(prod[j], inv, OFS);
         end
         // four-input XOR tree per output byte
         always_comb begin
            gf_byte_t acc;
            acc = '0;
            for (int j = 0; j < COL_BYTES; j++) acc ^= term[i][j];
            col_out[COL_W-1-BYTE_W*i -: BYTE_W] = acc;
         end
      end
   endgenerate

endmodule

// File: rtl/mix_col_unit.sv
module mix_col_unit
   import mcu_pkg::*;
#(
   parameter int unsigned COLS     = 4,
   parameter logic [7:0]  RED_POLY = 8'h1B
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mode_i,
   input  logic                in_valid,
   input  logic [32*COLS-1:0]  in_state,
   output logic                out_valid,
   output logic [32*COLS-1:0]  out_state
);

   localparam int unsigned STATE_W = COL_W * COLS;

   generate
      if (COLS != 1 && COLS != 4) begin : g_bad_cols
         $error("mix_col_unit: COLS must be 1 or 4");
      end
   endgenerate

   mc_mode_e           mode;
   logic [STATE_W-1:0] mixed;

   assign mode = mc_mode_e'(mode_i);

   generate
      for (genvar c = 0; c < COLS; c++) begin : g_col
         mc_column #(.RED_POLY(RED_POLY)) u_col (
            .inv     (mode == MC_INV),
            .col_in  (in_state[STATE_W-1-COL_W*c -: COL_W]),
            .col_out (mixed[STATE_W-1-COL_W*c -: COL_W])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_state <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_state <= mixed;
      end
   end

endmodule

// File: rtl/mcu_check.sv
module mcu_check #(
   parameter int unsigned COLS = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               mode_i,
   input logic               in_valid,
   input logic [32*COLS-1:0] in_state,
   input logic               out_valid,
   input logic [32*COLS-1:0] out_state
);

   localparam int unsigned SW = 32 * COLS;

   // independent multiply: shift-and-add over the multiplier bits
   function automatic logic [7:0] ck_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] p, x, y;
      p = 8'h00; x = a; y = b;
      for (int n = 0; n < 8; n++) begin
         if (y[0]) p ^= x;
         x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
         y = y >> 1;
      end
      return p;
   endfunction

   function automatic logic [31:0] ck_col(input logic [31:0] c, input logic inv);
      logic [7:0] row [4];
      logic [31:0] r;
      if (inv) begin
         row[0] = 8'h0E; row[1] = 8'h0B; row[2] = 8'h0D; row[3] = 8'h09;
      end else begin
         row[0] = 8'h02; row[1] = 8'h03; row[2] = 8'h01; row[3] = 8'h01;
      end
      r = '0;
      for (int i = 0; i < 4; i++)
         for (int j = 0; j < 4; j++)
            r[31-8*i -: 8] = r[31-8*i -: 8] ^ ck_mul(c[31-8*j -: 8], row[(j-i+4)%4]);
      return r;
   endfunction

   logic [SW-1:0] fwd_of_out, inv_of_out;

   always_comb begin
      for (int c = 0; c < COLS; c++) begin
         fwd_of_out[SW-1-32*c -: 32] = ck_col(out_state[SW-1-32*c -: 32], 1'b0);
         inv_of_out[SW-1-32*c -: 32] = ck_col(out_state[SW-1-32*c -: 32], 1'b1);
      end
   end

   p_rst_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_state == '0));

   p_valid_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_valid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_state));

   p_fwd_undo_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !mode_i) |=> (inv_of_out == $past(in_state)));

   p_inv_undo_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_i) |=> (fwd_of_out == $past(in_state)));

endmodule

bind mix_col_unit mcu_check #(.COLS(COLS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_i    (mode_i),
   .in_valid  (in_valid),
   .in_state  (in_state),
   .out_valid (out_valid),
   .out_state (out_state)
);

// File: tb/sim_mix_col_unit.sv
`timescale 1ns/100ps
module sim_mix_col_unit;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mode_i = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] in_state = '0;
   logic         out_valid;
   logic [127:0] out_state;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mix_col_unit #(.COLS(4)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .in_valid(in_valid),
      .in_state(in_state), .out_valid(out_valid), .out_state(out_state)
   );

   // ---------------- reference model from the matrix definitions
   function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] p = 8'h00;
      for (int n = 7; n >= 0; n--) begin
         p = {p[6:0], 1'b0} ^ (p[7] ? 8'h1B : 8'h00);
         if (b[n]) p ^= a;
      end
      return p;
   endfunction

   function automatic logic [127:0] model(input logic [127:0] s, input logic inv);
      logic [7:0] k [4];
      logic [127:0] r = '0;
      if (inv) begin k[0]=8'h0E; k[1]=8'h0B; k[2]=8'h0D; k[3]=8'h09; end
      else     begin k[0]=8'h02; k[1]=8'h03; k[2]=8'h01; k[3]=8'h01; end
      for (int c = 0; c < 4; c++)
         for (int i = 0; i < 4; i++) begin
            logic [7:0] acc = 8'h00;
            for (int j = 0; j < 4; j++)
               acc ^= m_mul(s[127-32*c-8*j -: 8], k[(j-i+4)%4]);
            r[127-32*c-8*i -: 8] = acc;
         end
      return r;
   endfunction

   function automatic logic [31:0] nxt(input logic [31:0] x);
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      return x;
   endfunction

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%032h expected=%032h", req, act, exp);
      end
   endtask

   // one valid beat, result sampled after the capturing edge
   task automatic run1(input logic m, input logic [127:0] s, output logic [127:0] r,
                       output logic v);
      @(negedge clk);
      mode_i = m; in_state = s; in_valid = 1'b1;
      @(negedge clk);
      r = out_state; v = out_valid;
      in_valid = 1'b0;
   endtask

   // ---------------- scenarios
   task automatic t_reset;
      @(negedge clk); @(negedge clk);
      check("R1 valid in reset", {127'd0, out_valid}, 128'd0);
      check("R1 state in reset", out_state, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after reset", {127'd0, out_valid}, 128'd0);
   endtask

   task automatic t_known;
      logic [127:0] r; logic v;
      logic [127:0] a = 128'hdb135345_f20a225c_01010101_2d26314c;
      logic [127:0] b = 128'h8e4da1bc_9fdc589d_01010101_4d7ebdf8;
      run1(1'b0, a, r, v);
      check("R2 forward known vector", r, b);
      run1(1'b1, b, r, v);
      check("R3 inverse known vector", r, a);
   endtask

   task automatic t_double;
      logic [127:0] r; logic v;
      logic [127:0] s = 128'h80000000_ff80c0fe_8181_8181_00000080;
      run1(1'b0, s, r, v);
      check("R4 forward high-bit reduction col0", {96'd0, r[127:96]}, {96'd0, 32'h1b80809b});
      check("R4 forward high-bit reduction", r, model(s, 1'b0));
      run1(1'b1, s, r, v);
      check("R4 inverse high-bit reduction", r, model(s, 1'b1));
   endtask

   task automatic t_latency;
      @(negedge clk);
      mode_i = 1'b0; in_state = 128'h1; in_valid = 1'b1;
      @(negedge clk);
      check("R5 valid one cycle later", {127'd0, out_valid}, 128'd1);
      in_valid = 1'b0;
      @(negedge clk);
      check("R5 valid drops with input", {127'd0, out_valid}, 128'd0);
   endtask

   task automatic t_hold;
      logic [127:0] r; logic v;
      logic [127:0] s = 128'h0123456789abcdef_fedcba9876543210;
      run1(1'b0, s, r, v);
      for (int n = 0; n < 3; n++) begin
         in_state = ~s ^ 128'(n); mode_i = n[0];
         @(negedge clk);
         check("R6 state held while idle", out_state, r);
         check("R6 valid low while idle", {127'd0, out_valid}, 128'd0);
      end
   endtask

   task automatic t_cols;
      logic [127:0] r0, r1; logic v;
      logic [127:0] s = 128'h11223344_55667788_99aabbcc_ddeeff00;
      logic [127:0] s2 = s;
      s2[63:32] = 32'h8f31c7e2;
      run1(1'b1, s, r0, v);
      run1(1'b1, s2, r1, v);
      check("R7 untouched columns 0-1", {64'd0, r1[127:64]}, {64'd0, r0[127:64]});
      check("R7 untouched column 3", {96'd0, r1[31:0]}, {96'd0, r0[31:0]});
      check("R7 changed column", r1, model(s2, 1'b1));
   endtask

   task automatic t_roundtrip;
      logic [31:0] x = 32'h2545f491;
      for (int n = 0; n < 6; n++) begin
         logic [127:0] s, y, z; logic v;
         x = nxt(x); s[127:96] = x; x = nxt(x); s[95:64] = x;
         x = nxt(x); s[63:32]  = x; x = nxt(x); s[31:0]  = x;
         run1(1'b0, s, y, v);
         check("R2 forward random", y, model(s, 1'b0));
         run1(1'b1, y, z, v);
         check("R8 inverse undoes forward", z, s);
         run1(1'b1, s, y, v);
         run1(1'b0, y, z, v);
         check("R8 forward undoes inverse", z, s);
      end
   endtask

   task automatic t_mode_mix;
      logic [127:0] ra, rb;
      logic va, vb;
      logic [127:0] a = 128'hc6c6c6c6_d4d4d4d5_f00dfeed_0badcafe;
      logic [127:0] b = 128'h5a5a5a5a_a5a5a5a5_13579bdf_2468ace0;
      @(negedge clk);
      mode_i = 1'b0; in_state = a; in_valid = 1'b1;
      @(negedge clk);
      ra = out_state; va = out_valid;
      mode_i = 1'b1; in_state = b;
      @(negedge clk);
      rb = out_state; vb = out_valid;
      in_valid = 1'b0;
      check("R9 forward beat before switch", ra, model(a, 1'b0));
      check("R9 inverse beat after switch", rb, model(b, 1'b1));
      check("R9 both beats valid", {126'd0, va, vb}, 128'd3);
   endtask

   initial begin
      t_reset();
      t_known();
      t_double();
      t_latency();
      t_hold();
      t_cols();
      t_roundtrip();
      t_mode_mix();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule